// File: doc/BRIEF.md
# Protected Wiper Command Executor

This block sits behind a serial front end that has already collected one 16-bit word per frame. It runs each accepted word as one command against a 10-bit wiper code, a small control register and a low-power (shutdown) flag. The nonvolatile slot storage is handled elsewhere. The block talks to that slot manager through one-cycle request pulses for store, restore and slot read. It takes back the last programmed address, the code held at that address, the program-success status and the data returned by slot reads.

Every frame leaves a response word for the front end to shift out during the following frame. A read command puts its result there. Any other command puts a copy of its own input word there, which keeps daisy-chained devices working. After reset, writes to the wiper and stores to slots are both locked. Software has to open them through the control register. A software reset can still reload the wiper from storage while the wiper is locked.

In each frame word, bits 13:10 carry the command and bits 9:0 carry the data. Bits 15:14 are not used.

Top module: `wiper_cmd_top`

## Requirements
- R1: After reset the wiper code is 0x200 (midscale), shutdown is 0, both enable bits are 0, the response word is 0x0000 and no request is active.
- R2: Command 7 sets the store-enable bit from D0 and the wiper-write-enable bit from D1. With wiper-write-enable at 1, command 1 loads D9:D0 into the wiper code. The result is visible one cycle after the frame.
- R3: With wiper-write-enable at 0, command 1 leaves the wiper code unchanged.
- R4: Command 3 with store-enable at 1 raises storeReq for exactly one cycle, with storeData equal to the wiper code. With store-enable at 0, command 3 raises no request.
- R5: Command 4 raises restoreReq for one cycle and clears shutdown, whatever the enable bits are. It also loads the wiper code with lastCode, or with 0x200 when lastAddr is 0.
- R6: Command 9 sets shutdown to D0. While shutdown is 1, all other commands still execute.
- R7: The response word is as follows. Command 2 gives the wiper code in bits 9:0. Command 6 gives lastAddr in bits 5:0. Command 8 gives the control bits in bits 3:0: progOk in bit 3, 0 in bit 2, wiper-write-enable in bit 1 and store-enable in bit 0. Every other accepted command gives a copy of the frame word.
- R8: Command 5 raises slotRdReq for one cycle, with slotRdAddr equal to D5:D0. The next slotRdValid loads slotRdData into bits 9:0 of the response word.
- R9: While smBusy is 1, an incoming frame changes nothing: no register, no response word and no request.
- R10: Command 0 and commands 10 to 15 change no state apart from the echoed response word.
- R11: The words 0x1C03, 0x0500 and 0x0800, sent in that order, leave a response word of 0x0100.
- R12: The program-success bit follows the progOk input only. Command 7 cannot write it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| frameValid | input | 1 | One-cycle strobe: frameWord holds a complete frame |
| frameWord | input | 16 | Decoded frame: command in 13:10, data in 9:0 |
| smBusy | input | 1 | Slot manager is busy programming |
| progOk | input | 1 | Slot manager reports that the last program succeeded |
| lastAddr | input | 6 | Address of the most recently programmed slot, 0 if none |
| lastCode | input | 10 | Code stored at lastAddr |
| slotRdValid | input | 1 | Slot read data is valid |
| slotRdData | input | 10 | Slot read data |
| wiperCode | output | 10 | Current wiper code |
| shutdown | output | 1 | Shutdown flag |
| sdoWord | output | 16 | Response word for the next frame |
| storeReq | output | 1 | Request to program the wiper code into the next slot |
| storeData | output | 10 | Code to program |
| restoreReq | output | 1 | Notifies a software-reset restore |
| slotRdReq | output | 1 | Request to read one slot |
| slotRdAddr | output | 6 | Slot address to read |

## Verification
A wrong enable bit shows up at the port in the cycle after the next wiper write or store command: the wiper either fails to move or moves when it should not, or storeReq appears or stays absent. A corrupted wiper code or shutdown flag is visible on its output from the very next cycle. A wrong response selection shows up in sdoWord one cycle after the frame. The bench therefore compares every output against a behavioural model on every clock, so a fault is reported in the cycle it first becomes visible.

// File: rtl/wiper_cmd_pkg.sv
package wiper_cmd_pkg;

  typedef enum logic [3:0] {
    OP_NOP       = 4'd0,
    OP_WR_WIPER  = 4'd1,
    OP_RD_WIPER  = 4'd2,
    OP_STORE     = 4'd3,
    OP_RESTORE   = 4'd4,
    OP_RD_SLOT   = 4'd5,
    OP_RD_LAST   = 4'd6,
    OP_WR_CTRL   = 4'd7,
    OP_RD_CTRL   = 4'd8,
    OP_SHUTDOWN  = 4'd9
  } opcode_e;

  typedef enum logic [1:0] {
    RESP_ECHO  = 2'd0,
    RESP_WIPER = 2'd1,
    RESP_LAST  = 2'd2,
    RESP_CTRL  = 2'd3
  } respSel_e;

  typedef struct packed {
    logic     wrWiper;
    logic     restore;
    logic     store;
    logic     slotRd;
    logic     wrCtrl;
    logic     wrShut;
    logic     respLoad;
    respSel_e respSel;
  } dpStrobe_t;

endpackage

// File: rtl/wiper_cmd_ctrl.sv
module wiper_cmd_ctrl
  import wiper_cmd_pkg::*;
#(
  parameter int CMD_W = 4
) (
  input  logic             frameValid,
  input  logic [CMD_W-1:0] cmdCode,
  input  logic             smBusy,
  input  logic             storeEn,
  input  logic             wiperEn,
  output dpStrobe_t        strobe
);

  logic accept;
  assign accept = frameValid && !smBusy;

  always_comb begin
    strobe = '0;
    strobe.respSel = RESP_ECHO;
    if (accept) begin
      strobe.respLoad = 1'b1;
      case (cmdCode)
        OP_WR_WIPER: strobe.wrWiper = wiperEn;
        OP_RD_WIPER: strobe.respSel = RESP_WIPER;
        OP_STORE:    strobe.store   = storeEn;
        OP_RESTORE:  strobe.restore = 1'b1;
        OP_RD_SLOT:  strobe.slotRd  = 1'b1;
        OP_RD_LAST:  strobe.respSel = RESP_LAST;
        OP_WR_CTRL:  strobe.wrCtrl  = 1'b1;
        OP_RD_CTRL:  strobe.respSel = RESP_CTRL;
        OP_SHUTDOWN: strobe.wrShut  = 1'b1;
        default:     strobe.respSel = RESP_ECHO;
      endcase
    end
  end

endmodule

// File: rtl/wiper_cmd_datapath.sv
module wiper_cmd_datapath
  import wiper_cmd_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int WIPER_W = 10,
  parameter int ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  dpStrobe_t          strobe,
  input  logic [WORD_W-1:0]  frameWord,
  input  logic               progOk,
  input  logic [ADDR_W-1:0]  lastAddr,
  input  logic [WIPER_W-1:0] lastCode,
  input  logic               slotRdValid,
  input  logic [WIPER_W-1:0] slotRdData,
  output logic               storeEn,
  output logic               wiperEn,
  output logic [WIPER_W-1:0] wiperCode,
  output logic               shutdown,
  output logic [WORD_W-1:0]  sdoWord,
  output logic               storeReq,
  output logic [WIPER_W-1:0] storeData,
  output logic               restoreReq,
  output logic               slotRdReq,
  output logic [ADDR_W-1:0]  slotRdAddr
);

  localparam logic [WIPER_W-1:0] MIDSCALE = WIPER_W'(1) << (WIPER_W - 1);
  localparam int CTRL_W = 4;

  logic [WIPER_W-1:0] restoreCode;
  logic [WORD_W-1:0]  respNext;

  assign restoreCode = (lastAddr == '0) ? MIDSCALE : lastCode;

  always_comb begin
    case (strobe.respSel)
      RESP_WIPER: respNext = {{(WORD_W-WIPER_W){1'b0}}, wiperCode};
      RESP_LAST:  respNext = {{(WORD_W-ADDR_W){1'b0}}, lastAddr};
      RESP_CTRL:  respNext = {{(WORD_W-CTRL_W){1'b0}}, progOk, 1'b0, wiperEn, storeEn};
      default:    respNext = frameWord;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wiperCode  <= MIDSCALE;
      storeEn    <= 1'b0;
      wiperEn    <= 1'b0;
      shutdown   <= 1'b0;
      sdoWord    <= '0;
      storeReq   <= 1'b0;
      storeData  <= '0;
      restoreReq <= 1'b0;
      slotRdReq  <= 1'b0;
      slotRdAddr <= '0;
    end else begin
      storeReq   <= strobe.store;
      restoreReq <= strobe.restore;
      slotRdReq  <= strobe.slotRd;
      if (strobe.store)   storeData  <= wiperCode;
      if (strobe.slotRd)  slotRdAddr <= frameWord[ADDR_W-1:0];
      if (strobe.wrWiper) wiperCode  <= frameWord[WIPER_W-1:0];
      else if (strobe.restore) wiperCode <= restoreCode;
      if (strobe.wrCtrl) begin
        storeEn <= frameWord[0];
        wiperEn <= frameWord[1];
      end
      if (strobe.wrShut)       shutdown <= frameWord[0];
      else if (strobe.restore) shutdown <= 1'b0;
      if (strobe.respLoad)  sdoWord <= respNext;
      else if (slotRdValid) sdoWord <= {{(WORD_W-WIPER_W){1'b0}}, slotRdData};
    end
  end

  // R3: a wiper write strobe from the decoder only ever arrives while unlocked
  a_r3_write_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.wrWiper |-> wiperEn);

  // R4: a store request is only issued if programming was enabled
  a_r4_store_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    storeReq |-> $past(storeEn));

  // R10: without a write or restore strobe the wiper holds
  a_r10_wiper_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe.wrWiper && !strobe.restore) |=> $stable(wiperCode));

  // R8: at most one request to the slot manager per cycle
  a_r8_one_request: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({storeReq, restoreReq, slotRdReq}));

  // R6: shutdown only rises after a shutdown command
  a_r6_shut_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shutdown) |-> $past(strobe.wrShut));

endmodule

// File: rtl/wiper_cmd_top.sv
module wiper_cmd_top
  import wiper_cmd_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int WIPER_W = 10,
  parameter int ADDR_W  = 6,
  parameter int CMD_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frameValid,
  input  logic [WORD_W-1:0]  frameWord,
  input  logic               smBusy,
  input  logic               progOk,
  input  logic [ADDR_W-1:0]  lastAddr,
  input  logic [WIPER_W-1:0] lastCode,
  input  logic               slotRdValid,
  input  logic [WIPER_W-1:0] slotRdData,
  output logic [WIPER_W-1:0] wiperCode,
  output logic               shutdown,
  output logic [WORD_W-1:0]  sdoWord,
  output logic               storeReq,
  output logic [WIPER_W-1:0] storeData,
  output logic               restoreReq,
  output logic               slotRdReq,
  output logic [ADDR_W-1:0]  slotRdAddr
);

  dpStrobe_t strobe;
  logic      storeEn;
  logic      wiperEn;

  wiper_cmd_ctrl #(.CMD_W(CMD_W)) u_ctrl (
    .frameValid (frameValid),
    .cmdCode    (frameWord[WIPER_W +: CMD_W]),
    .smBusy     (smBusy),
    .storeEn    (storeEn),
    .wiperEn    (wiperEn),
    .strobe     (strobe)
  );

  wiper_cmd_datapath #(
    .WORD_W (WORD_W),
    .WIPER_W(WIPER_W),
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .frameWord  (frameWord),
    .progOk     (progOk),
    .lastAddr   (lastAddr),
    .lastCode   (lastCode),
    .slotRdValid(slotRdValid),
    .slotRdData (slotRdData),
    .storeEn    (storeEn),
    .wiperEn    (wiperEn),
    .wiperCode  (wiperCode),
    .shutdown   (shutdown),
    .sdoWord    (sdoWord),
    .storeReq   (storeReq),
    .storeData  (storeData),
    .restoreReq (restoreReq),
    .slotRdReq  (slotRdReq),
    .slotRdAddr (slotRdAddr)
  );

  // R9: a frame offered while the slot manager is busy leaves all state alone
  a_r9_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
    (smBusy && !slotRdValid) |=> ($stable(wiperCode) && $stable(shutdown) &&
                                  $stable(sdoWord) && !storeReq && !restoreReq && !slotRdReq));

endmodule

// File: tb/test_wiper_cmd_top.sv
module test_wiper_cmd_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frameValid = 1'b0;
  logic [15:0] frameWord = '0;
  logic        smBusy = 1'b0;
  logic        progOk = 1'b0;
  logic [5:0]  lastAddr = '0;
  logic [9:0]  lastCode = '0;
  logic        slotRdValid = 1'b0;
  logic [9:0]  slotRdData = '0;
  logic [9:0]  wiperCode;
  logic        shutdown;
  logic [15:0] sdoWord;
  logic        storeReq;
  logic [9:0]  storeData;
  logic        restoreReq;
  logic        slotRdReq;
  logic [5:0]  slotRdAddr;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wiper_cmd_top i_wiper_cmd_top (
    .clk(clk), .rst_n(rst_n), .frameValid(frameValid), .frameWord(frameWord),
    .smBusy(smBusy), .progOk(progOk), .lastAddr(lastAddr), .lastCode(lastCode),
    .slotRdValid(slotRdValid), .slotRdData(slotRdData), .wiperCode(wiperCode),
    .shutdown(shutdown), .sdoWord(sdoWord), .storeReq(storeReq), .storeData(storeData),
    .restoreReq(restoreReq), .slotRdReq(slotRdReq), .slotRdAddr(slotRdAddr)
  );

  function automatic logic [9:0] slotContent(input logic [5:0] a);
    return 10'((int'(a) * 37 + 5) & 32'h3FF);
  endfunction

  // behavioural reference model
  int mWiper = 512, mShut = 0, mC0 = 0, mC1 = 0, mResp = 0;
  int mStore = 0, mStoreData = 0, mRestore = 0, mSlotReq = 0, mSlotAddr = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      mWiper = 512; mShut = 0; mC0 = 0; mC1 = 0; mResp = 0;
      mStore = 0; mStoreData = 0; mRestore = 0; mSlotReq = 0; mSlotAddr = 0;
    end else begin
      int cmd, dat;
      cmd = int'(frameWord[13:10]);
      dat = int'(frameWord[9:0]);
      mStore = 0; mRestore = 0; mSlotReq = 0;
      if (frameValid && !smBusy) begin
        mResp = int'(frameWord);
        if (cmd == 1 && mC1 == 1) mWiper = dat;
        else if (cmd == 2) mResp = mWiper;
        else if (cmd == 3 && mC0 == 1) begin mStore = 1; mStoreData = mWiper; end
        else if (cmd == 4) begin
          mRestore = 1; mShut = 0;
          mWiper = (lastAddr == 0) ? 512 : int'(lastCode);
        end
        else if (cmd == 5) begin mSlotReq = 1; mSlotAddr = dat % 64; end
        else if (cmd == 6) mResp = int'(lastAddr);
        else if (cmd == 7) begin mC0 = dat % 2; mC1 = (dat / 2) % 2; end
        else if (cmd == 8) mResp = (progOk ? 8 : 0) + mC1 * 2 + mC0;
        else if (cmd == 9) mShut = dat % 2;
      end else if (slotRdValid) begin
        mResp = int'(slotRdData);
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // slot manager stand-in: answers a slot read one cycle later
  always @(negedge clk) begin
    slotRdValid <= rst_n && slotRdReq;
    slotRdData  <= slotContent(slotRdAddr);
  end

  // compare against model every clock
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 model wiperCode", int'(wiperCode), mWiper);
      check("R6 model shutdown", int'(shutdown), mShut);
      check("R7 model sdoWord", int'(sdoWord), mResp);
      check("R4 model storeReq", int'(storeReq), mStore);
      if (mStore == 1) check("R4 model storeData", int'(storeData), mStoreData);
      check("R5 model restoreReq", int'(restoreReq), mRestore);
      check("R8 model slotRdReq", int'(slotRdReq), mSlotReq);
      if (mSlotReq == 1) check("R8 model slotRdAddr", int'(slotRdAddr), mSlotAddr);
    end
  end

  task automatic sendFrame(input logic [15:0] w);
    frameWord  = w;
    frameValid = 1'b1;
    @(negedge clk);
    frameValid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset wiper", int'(wiperCode), 512);
    check("R1 reset shutdown", int'(shutdown), 0);
    check("R1 reset sdo", int'(sdoWord), 0);
    check("R1 reset requests", int'({storeReq, restoreReq, slotRdReq}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ctrl bits after reset", int'(sdoWord), 0);

    // locked wiper write
    sendFrame(16'h0455);
    check("R3 locked write ignored", int'(wiperCode), 512);
    // store without enable
    sendFrame(16'h0C00);
    check("R4 store blocked", int'(storeReq), 0);
    // restore with empty memory, while locked
    lastCode = 10'h2AA;
    sendFrame(16'h1000);
    check("R5 restore empty midscale", int'(wiperCode), 512);
    check("R5 restore pulse", int'(restoreReq), 1);
    lastAddr = 6'd3;
    sendFrame(16'h1000);
    check("R5 restore locked from memory", int'(wiperCode), 'h2AA);
    @(negedge clk);
    check("R5 restore one cycle", int'(restoreReq), 0);

    // worked sequence
    sendFrame(16'h1C03);
    check("R7 echo of control write", int'(sdoWord), 'h1C03);
    sendFrame(16'h0500);
    check("R2 unlocked write", int'(wiperCode), 'h100);
    sendFrame(16'h0800);
    check("R11 wiper readback word", int'(sdoWord), 'h0100);
    sendFrame(16'h0000);
    check("R10 nop echo", int'(sdoWord), 0);
    check("R10 nop keeps wiper", int'(wiperCode), 'h100);
    sendFrame(16'hFC3F);
    check("R10 code 15 echo", int'(sdoWord), 'hFC3F);
    check("R10 code 15 keeps wiper", int'(wiperCode), 'h100);
    sendFrame(16'h2BFF);
    check("R10 code 10 keeps shutdown", int'(shutdown), 0);

    // store enabled
    sendFrame(16'h0C00);
    check("R4 store request", int'(storeReq), 1);
    check("R4 store data", int'(storeData), 'h100);
    @(negedge clk);
    check("R4 store one cycle", int'(storeReq), 0);

    sendFrame(16'h1800);
    check("R7 last address read", int'(sdoWord), 3);
    progOk = 1'b1;
    sendFrame(16'h2000);
    check("R7 control read", int'(sdoWord), 'hB);
    sendFrame(16'h1C0C);
    sendFrame(16'h2000);
    check("R12 success bit not writable", int'(sdoWord), 'h8);
    sendFrame(16'h0533);
    check("R3 relocked write ignored", int'(wiperCode), 'h100);

    // slot read
    sendFrame(16'h1414);
    check("R8 slot read request", int'(slotRdReq), 1);
    check("R8 slot read address", int'(slotRdAddr), 'h14);
    @(negedge clk);
    @(negedge clk);
    check("R8 slot data in response", int'(sdoWord), int'(slotContent(6'h14)));

    // shutdown
    sendFrame(16'h2401);
    check("R6 enter shutdown", int'(shutdown), 1);
    sendFrame(16'h0800);
    check("R6 read works in shutdown", int'(sdoWord), 'h100);
    sendFrame(16'h2400);
    check("R6 leave shutdown", int'(shutdown), 0);
    sendFrame(16'h2401);
    lastAddr = 6'd0;
    sendFrame(16'h1000);
    check("R5 restore clears shutdown", int'(shutdown), 0);
    check("R5 restore midscale", int'(wiperCode), 512);

    // busy
    smBusy = 1'b1;
    sendFrame(16'h1C03);
    sendFrame(16'h2401);
    sendFrame(16'h0C00);
    check("R9 busy no shutdown", int'(shutdown), 0);
    check("R9 busy no store", int'(storeReq), 0);
    check("R9 busy sdo unchanged", int'(sdoWord), 'h1000);
    smBusy = 1'b0;
    sendFrame(16'h2000);
    check("R9 busy left control locked", int'(sdoWord), 'h8);
    sendFrame(16'h0577);
    check("R9 wiper still locked", int'(wiperCode), 512);

    repeat (3) @(negedge clk);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule